// File: doc/BRIEF.md
# Time-code carrier amplitude modulator

This block generates a square-wave carrier from a free-running period counter and keys its amplitude by switching the PWM compare value. A large compare value gives full power at about 50% duty. A small compare value gives reduced power. With the default parameters and an 8 MHz clock, the carrier is close to 60 kHz.

Time is divided into seconds, and each second is divided into 61 ticks. At the start of each second the block raises a one-cycle strobe. A frame sequencer answers the strobe by presenting the next 2-bit symbol. The block holds reduced power for the first part of a second, and the length of that part depends on the symbol: short for a zero, medium for a one, long for a marker. For the rest of the second the carrier runs at full power.

Top module: `tc_carrier_mod`

## Requirements
- R1: The carrier has a period of CARR_TOP+1 clock cycles. In each period `carrier_out` is high for the first C cycles and low for the rest, where C is DUTY_FULL (66) at full power or DUTY_LOW (6) at reduced power.
- R2: A second lasts TICKS_PER_SEC×TICK_CYCLES clock cycles (61 ticks). `sec_strobe` is high for exactly one cycle, the first cycle of each second. The first strobe comes TICKS_PER_SEC×TICK_CYCLES cycles after the last reset cycle.
- R3: `sym_code` is sampled on the clock edge that ends a second, which is the edge just before the strobe cycle. The sampled symbol governs the second that then begins.
- R4: Code 2'b00 (zero) requests reduced power for ticks 0 to ZERO_TICKS-1 (12 ticks).
- R5: Code 2'b01 (one) requests reduced power for ticks 0 to ONE_TICKS-1 (30 ticks).
- R6: Code 2'b10 (marker) requests reduced power for ticks 0 to MARK_TICKS-1 (48 ticks). Code 2'b11 behaves exactly like a marker.
- R7: The compare value changes only at a carrier period boundary. The value for a period is the request in force during the last cycle of the previous period, when the counter is at CARR_TOP. No period is ever truncated.
- R8: A synchronous active-high `rst` clears the period, sub-tick and tick counters, selects full power and holds `sec_strobe` low. The first second after reset runs at full power whatever `sym_code` is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Count clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_code | input | 2 | Symbol for the next second: 00 zero, 01 one, 10/11 marker |
| carrier_out | output | 1 | PWM carrier output |
| sec_strobe | output | 1 | One-cycle pulse in the first cycle of each second |

## Verification
The strobe is due exactly one second length after the last reset cycle and every second length after that. The bench counts cycles from reset and compares the strobe in every cycle against that schedule. A symbol affects the second that follows the strobe after which it was applied, so the driver queues one expected window length per second and the monitor takes one entry off the queue at each strobe. A duty change shows up one carrier period after the tick boundary that causes it. With the bench's ratio of two periods per tick, a window of N ticks appears as periods 1 to 2N of the second, and the monitor checks both that count and the index of the first low period.

// File: rtl/tc_carrier_mod.sv
module tc_carrier_mod #(
  parameter int CARR_TOP      = 132,
  parameter int DUTY_FULL     = 66,
  parameter int DUTY_LOW      = 6,
  parameter int TICK_CYCLES   = 131072,
  parameter int TICKS_PER_SEC = 61,
  parameter int ZERO_TICKS    = 12,
  parameter int ONE_TICKS     = 30,
  parameter int MARK_TICKS    = 48
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] sym_code,
  output logic       carrier_out,
  output logic       sec_strobe
);
  localparam int CW = $clog2(CARR_TOP + 1);
  localparam int PW = $clog2(TICK_CYCLES);
  localparam int TW = $clog2(TICKS_PER_SEC);

  logic [CW-1:0] carr_cnt;
  logic [PW-1:0] pre_cnt;
  logic [TW-1:0] tick_cnt;
  logic [1:0]    cur_sym;
  logic          sym_valid;
  logic          duty_low_q;
  logic [TW-1:0] win_len;

  wire carr_top = carr_cnt == CW'(CARR_TOP);
  wire tick_en  = pre_cnt == PW'(TICK_CYCLES - 1);
  wire sec_end  = tick_en && (tick_cnt == TW'(TICKS_PER_SEC - 1));

  always_comb begin
    case (cur_sym)
      2'b00:   win_len = TW'(ZERO_TICKS);
      2'b01:   win_len = TW'(ONE_TICKS);
      default: win_len = TW'(MARK_TICKS);
    endcase
  end

  wire          want_low = sym_valid && (tick_cnt < win_len);
  wire [CW-1:0] cmp      = duty_low_q ? CW'(DUTY_LOW) : CW'(DUTY_FULL);

  assign carrier_out = carr_cnt < cmp;

  always_ff @(posedge clk) begin
    if (rst) begin
      carr_cnt   <= '0;
      pre_cnt    <= '0;
      tick_cnt   <= '0;
      cur_sym    <= 2'b00;
      sym_valid  <= 1'b0;
      duty_low_q <= 1'b0;
      sec_strobe <= 1'b0;
    end else begin
      carr_cnt   <= carr_top ? '0 : carr_cnt + 1'b1;
      pre_cnt    <= tick_en ? '0 : pre_cnt + 1'b1;
      sec_strobe <= sec_end;
      if (tick_en)
        tick_cnt <= sec_end ? '0 : tick_cnt + 1'b1;
      if (sec_end) begin
        cur_sym   <= sym_code;
        sym_valid <= 1'b1;
      end
      if (carr_top)
        duty_low_q <= want_low;
    end
  end
endmodule

// File: rtl/tc_carrier_chk.sv
module tc_carrier_chk #(
  parameter int CARR_TOP      = 132,
  parameter int TICKS_PER_SEC = 61,
  parameter int MARK_TICKS    = 48
) (
  input logic                                 clk,
  input logic                                 rst,
  input logic [$clog2(CARR_TOP + 1)-1:0]      carr_cnt,
  input logic [$clog2(TICKS_PER_SEC)-1:0]     tick_cnt,
  input logic                                 duty_low_q,
  input logic                                 sec_strobe,
  input logic                                 carrier_out
);
  localparam int CW = $clog2(CARR_TOP + 1);
  localparam int TW = $clog2(TICKS_PER_SEC);

  // R7
  duty_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (duty_low_q != $past(duty_low_q)) |-> ($past(carr_cnt) == CW'(CARR_TOP)));

  // R2
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    sec_strobe |=> !sec_strobe);

  // R2
  strobe_tick_chk: assert property (@(posedge clk) disable iff (rst)
    sec_strobe |-> (tick_cnt == '0));

  // R2
  tick_range_chk: assert property (@(posedge clk) disable iff (rst)
    tick_cnt < TW'(TICKS_PER_SEC));

  // R6
  low_window_chk: assert property (@(posedge clk) disable iff (rst)
    duty_low_q |-> (tick_cnt <= TW'(MARK_TICKS)));

  // R1
  carrier_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(carrier_out) |-> (carr_cnt == '0));

  // R8
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (carr_cnt == '0 && tick_cnt == '0 && !duty_low_q && !sec_strobe));
endmodule

bind tc_carrier_mod tc_carrier_chk #(
  .CARR_TOP(CARR_TOP),
  .TICKS_PER_SEC(TICKS_PER_SEC),
  .MARK_TICKS(MARK_TICKS)
) u_chk (
  .clk(clk),
  .rst(rst),
  .carr_cnt(carr_cnt),
  .tick_cnt(tick_cnt),
  .duty_low_q(duty_low_q),
  .sec_strobe(sec_strobe),
  .carrier_out(carrier_out)
);

// File: tb/tc_carrier_mod_tb.sv
module tc_carrier_mod_tb;
  localparam int TOP  = 7;
  localparam int FULL = 4;
  localparam int LOW  = 1;
  localparam int TCYC = 16;
  localparam int TPS  = 61;
  localparam int PER  = TOP + 1;
  localparam int SEC  = TPS * TCYC;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] sym_code = 2'b00;
  logic       carrier_out, sec_strobe;

  always #5 clk = ~clk;

  tc_carrier_mod #(
    .CARR_TOP(TOP), .DUTY_FULL(FULL), .DUTY_LOW(LOW), .TICK_CYCLES(TCYC),
    .TICKS_PER_SEC(TPS), .ZERO_TICKS(12), .ONE_TICKS(30), .MARK_TICKS(48)
  ) u_dut (
    .clk(clk), .rst(rst), .sym_code(sym_code),
    .carrier_out(carrier_out), .sec_strobe(sec_strobe)
  );

  int n_chk = 0;
  int n_bad = 0;
  int exp_q[$];
  logic rst_q = 1'b1;
  bit done = 1'b0;

  always @(posedge clk) rst_q <= rst;

  function automatic int win(input logic [1:0] s);
    if (s == 2'b00) return 12;
    if (s == 2'b01) return 30;
    return 48;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_strobe();
    @(negedge clk);
    while (!sec_strobe) @(negedge clk);
  endtask

  // monitor: classifies every carrier period, closes each second at its strobe
  int cyc = 0, pidx = 0, lows = 0, first = -1;
  logic [PER-1:0] pat;
  localparam logic [PER-1:0] PAT_FULL = PER'((1 << FULL) - 1);
  localparam logic [PER-1:0] PAT_LOW  = PER'((1 << LOW) - 1);

  always @(negedge clk) begin
    if (rst_q) begin
      check(carrier_out === 1'b1 && sec_strobe === 1'b0, "R8 reset outputs",
            {carrier_out, sec_strobe}, 2);
      pat = '0;
      pat[0] = carrier_out;
      cyc = 1; pidx = 0; lows = 0; first = -1;
    end else begin
      int pos;
      pos = cyc % PER;
      if (pos == 0) pat = '0;
      if (cyc % SEC == 0) begin
        check(sec_strobe === 1'b1, "R2 strobe due", sec_strobe, 1);
        if (exp_q.size() == 0) check(1'b0, "R3 no expected window queued", 0, 1);
        else begin
          int e;
          string tag;
          e = exp_q.pop_front();
          tag = (e == 12) ? "R4" : (e == 30) ? "R5" : (e == 48) ? "R6" : "R8";
          check(lows == 2 * e, {tag, " R3 low period count"}, lows, 2 * e);
          check(first == ((e > 0) ? 1 : -1), {tag, " R7 first low period"},
                first, (e > 0) ? 1 : -1);
        end
        pidx = 0; lows = 0; first = -1;
      end else if (sec_strobe === 1'b1) begin
        check(1'b0, "R2 strobe off schedule", 1, 0);
      end
      pat[pos] = carrier_out;
      if (pos == PER - 1) begin
        check(pat == PAT_FULL || pat == PAT_LOW, "R1 period shape", int'(pat), int'(PAT_FULL));
        if (pat == PAT_LOW) begin
          lows++;
          if (first < 0) first = pidx;
        end
        pidx++;
      end
      cyc++;
    end
  end

  // driver: applies symbols and queues the expected window per second
  initial begin
    logic [1:0] syms [6];
    syms = '{2'b00, 2'b01, 2'b10, 2'b11, 2'b01, 2'b00};
    repeat (4) @(posedge clk);
    exp_q.push_back(0);
    #1 rst = 1'b0;
    foreach (syms[i]) begin
      sym_code = syms[i];
      exp_q.push_back(win(syms[i]));
      wait_strobe();
    end
    sym_code = 2'b10;
    exp_q.push_back(48);
    wait_strobe();
    repeat (100) @(negedge clk);
    @(posedge clk);
    #1 rst = 1'b1;
    exp_q.delete();
    repeat (3) @(posedge clk);
    exp_q.push_back(0);
    exp_q.push_back(48);
    #1 rst = 1'b0;
    wait_strobe();
    wait_strobe();
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R3 all seconds consumed", exp_q.size(), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R2 actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule